// File: doc/BRIEF.md
# Command Ring Header Fetch Sequencer

This block runs one command ring of a DMA engine. Software programs the ring base address, a log2 ring size, the starting read offset and a writeback address. The write offset arrives through doorbell writes. While the read offset and the write offset differ, the block fetches the 32-bit header dword at `base + read offset` and decodes its opcode. NOP headers are skipped using the dword count they carry. Headers with an opcode above the known range raise a one-cycle error pulse and are stepped over. Every other header goes to a downstream dispatcher over a valid/ready handshake. At the handshake the dispatcher reports how many body dwords follow the header, so the read offset can step past the whole packet.

When the ring drains, the block drops its busy flag. If a writeback address has been programmed, it first stores the final read offset there with a single memory write. Offsets are byte offsets and wrap modulo the ring size.

Top module: `ring_fetch_seq`

## Requirements
- R1: After reset, `busy`, `hdr_valid`, `mem_rd_req`, `mem_wr_req`, `bad_op` and `size_err` are all 0. The ring size field resets to 6, the write offset resets to 0, and all other registers reset to 0.
- R2: While the read offset equals the write offset, no header read is issued and `busy` stays 0.
- R3: Each header read is a one-cycle `mem_rd_req` at address `base + read offset`. Only one read is outstanding at a time, and the next read waits for `mem_rd_vld`.
- R4: A header whose bits 7:0 are 0 is a NOP. It is never presented on `hdr_valid`, and the read offset advances by 4 plus 4 times the count in header bits 29:16.
- R5: A header with opcode (bits 7:0) from 1 to 15 is presented on `hdr_data` with `hdr_valid`, held stable until `hdr_ready`. At that handshake the read offset advances by 4 plus 4 times `hdr_body_dw`.
- R6: A header with opcode 16 or above gives a one-cycle `bad_op` pulse, is not presented, and advances the read offset by 4.
- R7: The ring size is 2 to the power of control-register bits 6:1. Read offsets wrap modulo that size.
- R8: A size field outside 6..62 drives `size_err` high, and no header read is issued until a legal size is written. Fetching then resumes.
- R9: When the ring empties with a nonzero writeback address, one `mem_wr_req` stores the read offset at that address before `busy` falls. With a zero address, no write occurs.
- R10: A doorbell write latches the new write offset at any time. It starts fetching when the block is idle and extends the current run when it is busy.
- R11: Configuration select codes are 0 base, 1 ring control, 2 read offset, 3 writeback address, and 4 doorbell (write offset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Configuration write data |
| mem_rd_req | output | 1 | Header read request |
| mem_rd_addr | output | AW | Header read address |
| mem_rd_vld | input | 1 | Read response valid |
| mem_rd_data | input | 32 | Read response dword |
| mem_wr_req | output | 1 | Read-offset writeback strobe |
| mem_wr_addr | output | AW | Writeback address |
| mem_wr_data | output | AW | Writeback value (read offset) |
| hdr_valid | output | 1 | Header offered to dispatcher |
| hdr_ready | input | 1 | Dispatcher accepts header |
| hdr_data | output | 32 | Header dword |
| hdr_body_dw | input | 14 | Body dword count, sampled at handshake |
| busy | output | 1 | Ring being processed |
| size_err | output | 1 | Ring size field out of range |
| bad_op | output | 1 | Unknown opcode pulse |

## Verification
The assertions assume that memory returns exactly one `mem_rd_vld` per request and none unrequested. They also assume the dispatcher may stall `hdr_ready` for any length of time. The bench memory model answers one cycle after each request, and the bench changes the ring control or read offset only while `busy` is low. Any change of the size field made in the same cycle as a read request is therefore never exercised.

// File: rtl/ring_fetch_seq.sv
module ring_fetch_seq #(
  parameter int AW     = 32,
  parameter int OP_MAX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_vld,
  input  logic [31:0]   mem_rd_data,
  output logic          mem_wr_req,
  output logic [AW-1:0] mem_wr_addr,
  output logic [AW-1:0] mem_wr_data,
  output logic          hdr_valid,
  input  logic          hdr_ready,
  output logic [31:0]   hdr_data,
  input  logic [13:0]   hdr_body_dw,
  output logic          busy,
  output logic          size_err,
  output logic          bad_op
);
  localparam logic [2:0] SEL_BASE = 3'd0;
  localparam logic [2:0] SEL_CTRL = 3'd1;
  localparam logic [2:0] SEL_RPTR = 3'd2;
  localparam logic [2:0] SEL_WB   = 3'd3;
  localparam logic [2:0] SEL_DB   = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_HAND, S_CHK, S_WB} st_t;

  st_t           st;
  logic [AW-1:0] base_q, rptr_q, wptr_q, wb_q;
  logic [5:0]    lg_q;
  logic [31:0]   hdr_q;
  logic          bad_q;
  logic [AW-1:0] mask;
  logic          pend;
  logic [7:0]    op_in;

  assign mask     = (AW'(1) << lg_q) - AW'(1);
  assign size_err = (lg_q < 6'd6) || (lg_q > 6'd62);
  assign pend     = rptr_q != wptr_q;
  assign op_in    = mem_rd_data[7:0];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [13:0] n,
                                         input logic [AW-1:0] m);
    return (p + AW'({n, 2'b00}) + AW'(4)) & m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      rptr_q <= '0;
      wptr_q <= '0;
      wb_q   <= '0;
      lg_q   <= 6'd6;
      hdr_q  <= '0;
      bad_q  <= 1'b0;
    end else begin
      bad_q <= 1'b0;
      if (cfg_we) begin
        case (cfg_sel)
          SEL_BASE: base_q <= cfg_wdata;
          SEL_CTRL: lg_q   <= cfg_wdata[6:1];
          SEL_RPTR: rptr_q <= cfg_wdata & mask;
          SEL_WB:   wb_q   <= cfg_wdata;
          SEL_DB:   wptr_q <= cfg_wdata & mask;
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (pend && !size_err) st <= S_REQ;
        S_REQ:  st <= size_err ? S_IDLE : S_WAIT;
        S_WAIT: if (mem_rd_vld) begin
          hdr_q <= mem_rd_data;
          if (op_in == 8'd0) begin
            rptr_q <= step(rptr_q, mem_rd_data[29:16], mask);
            st     <= S_CHK;
          end else if (op_in > 8'(OP_MAX)) begin
            rptr_q <= step(rptr_q, 14'd0, mask);
            bad_q  <= 1'b1;
            st     <= S_CHK;
          end else begin
            st <= S_HAND;
          end
        end
        S_HAND: if (hdr_ready) begin
          rptr_q <= step(rptr_q, hdr_body_dw, mask);
          st     <= S_CHK;
        end
        S_CHK: begin
          if (pend && !size_err)   st <= S_REQ;
          else if (!pend && wb_q != '0) st <= S_WB;
          else                     st <= S_IDLE;
        end
        S_WB:    st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_req  = (st == S_REQ) && !size_err;
  assign mem_rd_addr = base_q + rptr_q;
  assign mem_wr_req  = st == S_WB;
  assign mem_wr_addr = wb_q;
  assign mem_wr_data = rptr_q;
  assign hdr_valid   = st == S_HAND;
  assign hdr_data    = hdr_q;
  assign busy        = st != S_IDLE;
  assign bad_op      = bad_q;
endmodule

// File: rtl/ring_fetch_seq_chk.sv
module ring_fetch_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd_req,
  input logic          mem_rd_vld,
  input logic [31:0]   mem_rd_data,
  input logic          mem_wr_req,
  input logic [AW-1:0] mem_wr_addr,
  input logic          hdr_valid,
  input logic          hdr_ready,
  input logic [31:0]   hdr_data,
  input logic          size_err,
  input logic          bad_op,
  input logic          busy
);
  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);
  a_r5_hold_header: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data));
  a_r4_nop_not_offered: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_vld && mem_rd_data[7:0] == 8'd0 |=> !hdr_valid);
  a_r6_bad_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |=> !bad_op && !hdr_valid);
  a_r8_no_fetch_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !mem_rd_req);
  a_r9_wb_target: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> mem_wr_addr != '0 && busy);
endmodule

bind ring_fetch_seq ring_fetch_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd_req(mem_rd_req), .mem_rd_vld(mem_rd_vld),
  .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
  .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
  .size_err(size_err), .bad_op(bad_op), .busy(busy)
);

// File: tb/ring_fetch_seq_tb_top.sv
module ring_fetch_seq_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        mem_rd_req, mem_wr_req, hdr_valid, busy, size_err, bad_op;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data, hdr_data;
  logic        mem_rd_vld = 0;
  logic [31:0] mem_rd_data = 0;
  logic        rdy_en = 1;
  logic [13:0] body;

  int vectors = 0, errors = 0, bad_seen = 0, cyc = 0;
  logic [31:0] mem [64];
  logic [31:0] q_rd[$];
  logic [31:0] q_hdr[$];
  logic [63:0] q_wb[$];

  always #10 clk = ~clk;

  assign body = {10'd0, hdr_data[19:16]};

  ring_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_vld(mem_rd_vld),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .hdr_valid(hdr_valid), .hdr_ready(rdy_en),
    .hdr_data(hdr_data), .hdr_body_dw(body), .busy(busy), .size_err(size_err),
    .bad_op(bad_op)
  );

  always @(posedge clk) begin
    mem_rd_vld  <= mem_rd_req;
    mem_rd_data <= mem[mem_rd_addr[7:2]];
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_req) begin
        if (q_rd.size() == 0) chk("R3/R2/R8 unexpected read", {32'd0, mem_rd_addr}, 64'hFFFF);
        else chk("R3 read address", {32'd0, mem_rd_addr}, {32'd0, q_rd.pop_front()});
      end
      if (hdr_valid && rdy_en) begin
        if (q_hdr.size() == 0) chk("R5 unexpected header", {32'd0, hdr_data}, 64'hFFFF);
        else chk("R5 header", {32'd0, hdr_data}, {32'd0, q_hdr.pop_front()});
      end
      if (mem_wr_req) begin
        if (q_wb.size() == 0) chk("R9 unexpected writeback", {mem_wr_addr, mem_wr_data}, 64'hFFFF);
        else chk("R9 writeback", {mem_wr_addr, mem_wr_data}, q_wb.pop_front());
      end
      if (bad_op) bad_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      report();
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic drain();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic queues_empty(input string req);
    chk({req, " pending reads"}, q_rd.size(), 0);
    chk({req, " pending headers"}, q_hdr.size(), 0);
    chk({req, " pending writebacks"}, q_wb.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 hdr_valid", hdr_valid, 0);
    chk("R1 rd_req", mem_rd_req, 0);
    chk("R1 wr_req", mem_wr_req, 0);
    chk("R1 bad_op", bad_op, 0);
    chk("R1 size_err", size_err, 0);
    rst_n = 1;

    // R11 select codes; R2 idle with equal offsets
    wr(3'd0, 32'h1000);
    wr(3'd1, 32'h10);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h2000);
    repeat (5) @(negedge clk);
    chk("R2 idle busy", busy, 0);

    // R3 R4 R5 R6 R9 main run
    mem[0] = 32'h0001_0002;
    mem[2] = 32'h0003_0000;
    mem[6] = 32'h0000_0020;
    mem[7] = 32'h0000_0105;
    q_rd.push_back(32'h1000); q_rd.push_back(32'h1008);
    q_rd.push_back(32'h1018); q_rd.push_back(32'h101C);
    q_hdr.push_back(32'h0001_0002); q_hdr.push_back(32'h0000_0105);
    q_wb.push_back({32'h2000, 32'd32});
    wr(3'd4, 32'd32);
    drain();
    chk("R6 bad_op count", bad_seen, 1);
    queues_empty("R4");

    // R7 wrap at ring end
    mem[62] = 32'h0000_0001;
    mem[63] = 32'h0000_0003;
    mem[0]  = 32'h0000_0004;
    q_rd.push_back(32'h10F8); q_rd.push_back(32'h10FC); q_rd.push_back(32'h1000);
    q_hdr.push_back(32'h1); q_hdr.push_back(32'h3); q_hdr.push_back(32'h4);
    q_wb.push_back({32'h2000, 32'd4});
    wr(3'd2, 32'hF8);
    wr(3'd4, 32'd4);
    drain();
    queues_empty("R7");

    // R9 no writeback with zero address
    wr(3'd3, 32'h0);
    mem[1] = 32'h0;
    q_rd.push_back(32'h1004);
    wr(3'd4, 32'd8);
    drain();
    chk("R9 busy cleared", busy, 0);
    queues_empty("R9");

    // R8 illegal sizes stall fetch
    wr(3'd1, 32'h0A);
    chk("R8 size 5 err", size_err, 1);
    mem[2] = 32'h0000_0001;
    wr(3'd4, 32'd12);
    repeat (8) @(negedge clk);
    chk("R8 no fetch busy", busy, 0);
    wr(3'd1, 32'h7E);
    chk("R8 size 63 err", size_err, 1);
    q_rd.push_back(32'h1008);
    q_hdr.push_back(32'h1);
    wr(3'd1, 32'h10);
    chk("R8 size 8 ok", size_err, 0);
    drain();
    queues_empty("R8");

    // R10 doorbell while busy, dispatcher stalled
    rdy_en = 0;
    mem[3] = 32'h0000_0002;
    mem[4] = 32'h0000_0004;
    q_rd.push_back(32'h100C); q_rd.push_back(32'h1010);
    q_hdr.push_back(32'h2); q_hdr.push_back(32'h4);
    wr(3'd4, 32'd16);
    repeat (6) @(negedge clk);
    chk("R5 held while stalled", {hdr_valid, hdr_data}, {1'b1, 32'h2});
    wr(3'd4, 32'd20);
    rdy_en = 1;
    drain();
    queues_empty("R10");
    chk("R6 bad_op total", bad_seen, 1);
    report();
  end
endmodule